// File: doc/BRIEF.md
# Latch-Pair Sliced Register Memory

This block is a small memory array with one shared word address, a per-slice write enable and one combinational read port. Every stored bit is built from two level-sensitive latches in series: a front latch that follows the write data while the slice's gated clock is low, and a holding latch that takes the front latch's value while the gated clock is high. The pair behaves like an edge-triggered cell that samples at the rising clock edge. It costs less area than a flip-flop when the target library has compact latches.

Each word holds a row of write slices. Every slice of every word owns one clock gate. The gate latches (write enable AND word select AND not-in-reset) during the low phase of the system clock and ANDs the result with the clock. It also drives one inverter, and that inverted gated clock is shared by every front latch in the slice. A build parameter replaces the latch pair with an edge-triggered flop on the gated clock and leaves out the front latch. The port behaviour is the same in both variants. Read data is the addressed word, picked by an AND-OR multiplexer from one-hot word selects.

Top module: `latchram_array`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, no write takes effect. Stored words keep their contents and the read port keeps working. Reset does not clear the array.
- R2: When `rst_n` is high and `wr_en[s]` is high at a rising edge of `clk`, bits `wr_data[s*SLICE_W +: SLICE_W]` are stored into the word whose binary index is `addr`. They are readable on `rd_data` from that edge on.
- R3: A write changes only the addressed word. Every other word keeps its value.
- R4: A slice whose `wr_en` bit is low at the edge keeps its previous bits in the addressed word, while the enabled slices of the same word are updated.
- R5: `rd_data` is a combinational function of `addr` and the stored contents. A change of `addr` with no clock edge shows the newly addressed word.
- R6: The stored value is the `wr_data` present at the rising edge. A change of `wr_data` during the high phase that follows, with the enable still high, is not stored.
- R7: Writes in consecutive cycles are all taken. Two writes to the same word leave the later data, and a write to another word in the next cycle is kept as well.
- R8: The latch-pair variant (`STORE = STORE_LATCH`) and the flop variant (`STORE = STORE_FLOP`) give identical `rd_data` for any sequence of writes and reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. Writes are sampled at its rising edge. |
| rst_n | input | 1 | Active-low reset, sampled at the rising edge. It blocks writes. |
| addr | input | AW = $clog2(WORDS) | Binary word index used for both write and read. |
| wr_en | input | SLICES = WIDTH/SLICE_W | Write enable, one bit per slice. Bit s covers data bits [s*SLICE_W +: SLICE_W]. |
| wr_data | input | WIDTH | Write data. |
| rd_data | output | WIDTH | Contents of the addressed word, combinational. |

## Verification
A write is due one rising edge after the bench presents it. The bench drives every input 2 ns after a falling edge, so the data is settled at the next rising edge. It reads the written word back in a later low phase, well before the following rising edge. A read has no latency: the bench sets `addr` in the low phase and samples `rd_data` a few nanoseconds later, with no clock edge in between. The data-change test moves `wr_data` 3 ns after the sampling edge, while the enable is still high, and expects the earlier value. The embedded properties sample at rising edges and compare against the values sampled one edge earlier. The bench instantiates both storage variants on shared stimulus, with 4-bit slices so that masking can be exercised.

// File: rtl/latchram_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the latch-pair memory.
// Assumes: nothing; pure type definitions.
package latchram_pkg;

    // Storage cell variant chosen at build time.
    typedef enum logic {
        STORE_LATCH = 1'b0,
        STORE_FLOP  = 1'b1
    } storage_e;

endpackage

// File: rtl/latchram_decode.sv
`timescale 1ns/1ps
// Module: latchram_decode
// Turns a binary word index into a one-hot word select.
// Assumes: an index at or above WORDS selects no word.
module latchram_decode #(
    parameter int WORDS = 8,
    localparam int AW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic [AW-1:0]    addr,
    output logic [WORDS-1:0] word_sel
);

    // One-hot decode of the word index.
    always_comb begin
        word_sel = '0;
        for (int w = 0; w < WORDS; w++) begin
            if (addr == w[AW-1:0]) begin
                word_sel[w] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/latchram_clkgate.sv
`timescale 1ns/1ps
// Module: latchram_clkgate
// Glitch-free clock gate for one slice of one word. The enable is held in
// a latch that is open while clk is low. It is then ANDed with clk, so the
// gated clock can only rise with clk. In latch mode one inverter makes the
// shared inverted gated clock for the slice's front latches.
// Assumes: wr_en and word_sel settle during the low phase of clk.
module latchram_clkgate
    import latchram_pkg::*;
#(
    parameter storage_e STORE = STORE_LATCH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic word_sel,
    output logic en_q,
    output logic gclk,
    output logic gclk_n
);

    // Enable latch: transparent while clk is low, closed while high.
    always_latch begin
        if (!clk) begin
            en_q = wr_en & word_sel & rst_n;
        end
    end

    // Gated clock: clk qualified by the held enable.
    assign gclk = clk & en_q;

    generate
        if (STORE == STORE_LATCH) begin : g_inv
            // One shared inverter per slice for the front latches.
            assign gclk_n = ~gclk;
        end else begin : g_no_inv
            // Flop storage needs no inverted clock.
            assign gclk_n = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/latchram_bit.sv
`timescale 1ns/1ps
// Module: latchram_bit
// One storage bit. Latch variant: a front latch open while gclk_n is high
// feeds a holding latch open while gclk is high. Both are positive-level
// latches; only the inverted clock makes the front one negative. Flop
// variant: one edge-triggered cell on gclk, with gclk_n left unused.
// Assumes: gclk_n is the inverse of gclk; contents are not reset.
module latchram_bit
    import latchram_pkg::*;
#(
    parameter storage_e STORE = STORE_LATCH
) (
    input  logic gclk,
    input  logic gclk_n,
    input  logic d,
    output logic q
);

    generate
        if (STORE == STORE_LATCH) begin : g_latch
            logic front;
            // Front latch follows d while the gated clock is low.
            always_latch begin
                if (gclk_n) begin
                    front = d;
                end
            end
            // Holding latch passes the front latch while the gated clock is high.
            always_latch begin
                if (gclk) begin
                    q = front;
                end
            end
        end else begin : g_flop
            logic unused_gclk_n;
            assign unused_gclk_n = gclk_n;
            // Edge cell captures d on the gated clock's rising edge.
            always_ff @(posedge gclk) begin
                q <= d;
            end
        end
    endgenerate

endmodule

// File: rtl/latchram_rdmux.sv
`timescale 1ns/1ps
// Module: latchram_rdmux
// AND-OR read multiplexer that stands in for a tristate read bus.
// Assumes: word_sel has at most one bit set; with none set the output is 0.
module latchram_rdmux #(
    parameter int WORDS = 8,
    parameter int WIDTH = 8
) (
    input  logic [WORDS-1:0][WIDTH-1:0] word_q,
    input  logic [WORDS-1:0]            word_sel,
    output logic [WIDTH-1:0]            rd_data
);

    // OR together every word masked by its select.
    always_comb begin
        rd_data = '0;
        for (int w = 0; w < WORDS; w++) begin
            rd_data = rd_data | (word_q[w] & {WIDTH{word_sel[w]}});
        end
    end

endmodule

// File: rtl/latchram_array.sv
`timescale 1ns/1ps
// Module: latchram_array (top)
// WORDS x WIDTH memory with per-slice write enables and one combinational
// read port. Each word/slice pair has its own clock gate. Each bit is a
// latch pair or a flop, chosen by STORE.
// Assumes: WIDTH is a multiple of SLICE_W; inputs change only while clk is
// low or after the rising edge, never across it.
module latchram_array
    import latchram_pkg::*;
#(
    parameter int       WORDS   = 8,
    parameter int       WIDTH   = 8,
    parameter int       SLICE_W = 8,
    parameter storage_e STORE   = STORE_LATCH,
    localparam int AW     = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int SLICES = WIDTH / SLICE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [SLICES-1:0] wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data
);

    logic [WORDS-1:0]              word_sel;
    logic [WORDS-1:0][WIDTH-1:0]   word_q;
    logic [SLICES-1:0][WORDS-1:0]  en_grid;

    latchram_decode #(.WORDS(WORDS)) u_decode (
        .addr     (addr),
        .word_sel (word_sel)
    );

    generate
        for (genvar w = 0; w < WORDS; w++) begin : g_word
            for (genvar s = 0; s < SLICES; s++) begin : g_slice
                logic gclk;
                logic gclk_n;
                latchram_clkgate #(.STORE(STORE)) u_gate (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .wr_en    (wr_en[s]),
                    .word_sel (word_sel[w]),
                    .en_q     (en_grid[s][w]),
                    .gclk     (gclk),
                    .gclk_n   (gclk_n)
                );
                for (genvar b = 0; b < SLICE_W; b++) begin : g_bit
                    latchram_bit #(.STORE(STORE)) u_bit (
                        .gclk   (gclk),
                        .gclk_n (gclk_n),
                        .d      (wr_data[s*SLICE_W + b]),
                        .q      (word_q[w][s*SLICE_W + b])
                    );
                end
            end
        end
    endgenerate

    latchram_rdmux #(.WORDS(WORDS), .WIDTH(WIDTH)) u_rdmux (
        .word_q   (word_q),
        .word_sel (word_sel),
        .rd_data  (rd_data)
    );

    // R3: the decoder never selects more than one word.
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(word_sel))
        else $error("p_sel_onehot_r3");

    generate
        for (genvar s = 0; s < SLICES; s++) begin : g_chk
            // R3: at most one word's gate is enabled for a slice at a write edge.
            p_one_word_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(en_grid[s]))
                else $error("p_one_word_gated_r3");

            // R2/R6: data present at the write edge is read back one edge later.
            p_write_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (rst_n && wr_en[s]) |=>
                    ((addr != $past(addr)) ||
                     (rd_data[s*SLICE_W +: SLICE_W] === $past(wr_data[s*SLICE_W +: SLICE_W]))))
                else $error("p_write_visible_r2");
        end
    endgenerate

    // R4: with no enable set, the addressed word holds its value.
    p_hold_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && (wr_en == '0)) |=>
            ((addr != $past(addr)) || (rd_data === $past(rd_data))))
        else $error("p_hold_no_write_r4");

endmodule

// File: tb/latchram_array_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios on both storage variants with 4-bit slices.
module latchram_array_bench;
    import latchram_pkg::*;

    localparam int WORDS = 8;
    localparam int WIDTH = 8;
    localparam int SW    = 4;
    localparam int NS    = WIDTH / SW;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [2:0]      addr;
    logic [NS-1:0]   wr_en;
    logic [WIDTH-1:0] wr_data;
    logic [WIDTH-1:0] rd_lat;
    logic [WIDTH-1:0] rd_ff;

    logic [WIDTH-1:0] ref_mem [WORDS];
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    latchram_array #(.WORDS(WORDS), .WIDTH(WIDTH), .SLICE_W(SW), .STORE(STORE_LATCH))
        u_latchram_array (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                          .wr_data(wr_data), .rd_data(rd_lat));

    latchram_array #(.WORDS(WORDS), .WIDTH(WIDTH), .SLICE_W(SW), .STORE(STORE_FLOP))
        u_latchram_array_ff (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                             .wr_data(wr_data), .rd_data(rd_ff));

    task automatic check(input string req, input logic [WIDTH-1:0] got,
                         input logic [WIDTH-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Presents one write for the next rising edge; updates the model if asked.
    task automatic put_write(input logic [2:0] a, input logic [NS-1:0] m,
                             input logic [WIDTH-1:0] d, input bit upd);
        @(negedge clk); #2;
        addr = a; wr_en = m; wr_data = d;
        if (upd) begin
            for (int s = 0; s < NS; s++) begin
                if (m[s]) ref_mem[a][s*SW +: SW] = d[s*SW +: SW];
            end
        end
    endtask

    task automatic go_idle();
        @(negedge clk); #2;
        wr_en = '0;
    endtask

    // Reads a word in the low phase and checks both variants against the model.
    task automatic read_chk(input logic [2:0] a, input string req);
        @(negedge clk); #2;
        wr_en = '0; addr = a;
        #5;
        check({req, " latch"}, rd_lat, ref_mem[a]);
        check({req, " flop"}, rd_ff, ref_mem[a]);
    endtask

    task automatic t_fill_r2();
        for (int w = 0; w < WORDS; w++) put_write(3'(w), 2'b11, 8'(w * 8'h11) ^ 8'hA5, 1);
        go_idle();
        for (int w = 0; w < WORDS; w++) read_chk(3'(w), "R2");
    endtask

    task automatic t_mask_r4();
        put_write(3'd2, 2'b01, 8'hF0, 1);
        put_write(3'd5, 2'b10, 8'h9E, 1);
        go_idle();
        read_chk(3'd2, "R4");
        read_chk(3'd5, "R4");
    endtask

    task automatic t_isolate_r3();
        put_write(3'd6, 2'b11, 8'h3C, 1);
        go_idle();
        for (int w = 0; w < WORDS; w++) read_chk(3'(w), "R3");
    endtask

    task automatic t_comb_read_r5();
        @(negedge clk); #2;
        wr_en = '0; addr = 3'd1;
        #3 check("R5 latch", rd_lat, ref_mem[1]);
        check("R5 flop", rd_ff, ref_mem[1]);
        addr = 3'd4;
        #3 check("R5 latch", rd_lat, ref_mem[4]);
        check("R5 flop", rd_ff, ref_mem[4]);
    endtask

    task automatic t_late_data_r6();
        @(negedge clk); #2;
        addr = 3'd0; wr_en = 2'b11; wr_data = 8'h5A;
        @(posedge clk); #3;
        wr_data = 8'hC3;
        ref_mem[0] = 8'h5A;
        go_idle();
        read_chk(3'd0, "R6");
    endtask

    task automatic t_back_to_back_r7();
        put_write(3'd3, 2'b11, 8'h11, 1);
        put_write(3'd3, 2'b11, 8'h22, 1);
        put_write(3'd4, 2'b11, 8'h33, 1);
        go_idle();
        read_chk(3'd3, "R7");
        read_chk(3'd4, "R7");
    endtask

    task automatic t_reset_r1();
        @(negedge clk); #2;
        rst_n = 1'b0;
        put_write(3'd1, 2'b11, ~ref_mem[1], 0);
        go_idle();
        read_chk(3'd1, "R1 in reset");
        @(negedge clk); #2;
        rst_n = 1'b1;
        read_chk(3'd1, "R1");
    endtask

    task automatic t_random_r8();
        for (int i = 0; i < 300; i++) begin
            put_write(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)),
                      8'($urandom_range(0, 255)), 1);
        end
        go_idle();
        for (int w = 0; w < WORDS; w++) begin
            read_chk(3'(w), "R8");
            check("R8 variants agree", rd_lat, rd_ff);
        end
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; wr_en = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        t_fill_r2();
        t_mask_r4();
        t_isolate_r3();
        t_comb_read_r5();
        t_late_data_r6();
        t_back_to_back_r7();
        t_reset_r1();
        t_random_r8();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule